// File: doc/BRIEF.md
# SDRAM Read Burst Output Sequencer

This block is a synthesizable device-side model of the read data path of a four-bank synchronous DRAM. Each clock it samples a read request and a precharge request. A read request carries a bank and a start column. A precharge request carries a bank. From these it drives a 16-bit data bus and an output-enable signal. The words come from a fixed storage pattern. CAS latency and burst length are static mode inputs. The block generates the burst column sequence, delays every word by the CAS latency, and cuts a burst short when the bank being read is precharged.

A read is accepted on a clock edge. From that point the block issues one column per clock into a delay line, for as many clocks as the burst length. A precharge to the reading bank stops any further issue. Words that were already issued still leave the delay line, so the bus shuts off exactly one CAS latency after the precharge. A new read replaces any burst in progress.

A read and a precharge to the same bank in the same cycle is a protocol conflict. The block raises an error flag for that cycle and does not start the read.

Top module: `sdram_rd_seq`

## Requirements
- R1: While reset is held, and in the first cycle after it, `oe_o` is 0, `dq_o` is 0 and `err_o` is 0.
- R2: A read sampled on clock edge E puts its first word on the bus after edge E+CL, and each later word one clock after the one before. CL is 2 when `cl_sel`=0 and 3 when `cl_sel`=1.
- R3: Without a precharge, a read outputs BL words. BL is 1, 2, 4 or 8 for `bl_sel` = 0, 1, 2 or 3.
- R4: Word i of a burst starting at column c reads column (c & ~(BL-1)) | ((c+i) & (BL-1)). The burst therefore wraps inside a block of BL columns aligned to BL.
- R5: The word stored at bank b and column c has b in bits 15:14, zeros in bits 13:8, and c in bits 7:0.
- R6: A precharge to the reading bank sampled k edges after the read, with 1 <= k < BL, yields exactly k words. `oe_o` is low from edge (precharge edge + CL) onward.
- R7: A precharge to the reading bank sampled BL or more edges after the read leaves the full burst unchanged.
- R8: A precharge to a bank other than the reading bank does not change the burst in progress. This holds also when it is sampled in the same cycle as the read.
- R9: In any cycle with no burst word scheduled, `oe_o` is 0 and `dq_o` is 0.
- R10: A read and a precharge to the same bank sampled on the same edge raise `err_o` for the one cycle after that edge, and no word of that read is output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cl_sel | input | 1 | CAS latency select: 0 = 2, 1 = 3 (static) |
| bl_sel | input | 2 | Burst length select: 1, 2, 4, 8 (static) |
| rd_en | input | 1 | Read request this cycle |
| rd_bank | input | 2 | Bank of the read |
| rd_col | input | COL_W | Start column of the read |
| pre_en | input | 1 | Precharge request this cycle |
| pre_bank | input | 2 | Bank of the precharge |
| dq_o | output | DATA_W | Read data bus, zero when not enabled |
| oe_o | output | 1 | Data output enable |
| err_o | output | 1 | Same-cycle read/precharge conflict on one bank |

## Verification
Full bursts at a column inside its aligned block show the wrap order and the data pattern. The same bursts run under both latencies and all four burst lengths, which separates latency errors from length errors. Precharges to the reading bank at spacings of one to three clocks, and at the burst length and beyond, show whether the cut counts words from the read and whether a late precharge is harmless. A precharge to another bank, both mid-burst and in the read's own cycle, separates a bank-matched cut from a cut that reacts to any precharge. The same-bank conflict case shows that the error flag is raised and that no data leaks out.

// File: rtl/sdram_rd_pkg.sv
package sdram_rd_pkg;
    localparam int BANK_W = 2;
    localparam int MIN_CL = 2;
    localparam int MAX_CL = 3;
    localparam int MAX_BL = 8;
    localparam int IDX_W  = $clog2(MAX_BL);
endpackage

// File: rtl/sdram_rd_addr.sv
module sdram_rd_addr
    import sdram_rd_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic [COL_W-1:0] start_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic [1:0]       bl_sel,
    output logic [COL_W-1:0] col_o
);
    logic [COL_W-1:0] mask;
    logic [COL_W-1:0] sum;

    always_comb begin
        mask  = COL_W'(({{IDX_W{1'b0}}, 1'b1} << bl_sel) - 1'b1);
        sum   = start_i + COL_W'(idx_i);
        col_o = (start_i & ~mask) | (sum & mask);
    end
endmodule

// File: rtl/sdram_rd_store.sv
module sdram_rd_store
    import sdram_rd_pkg::*;
#(
    parameter int COL_W  = 8,
    parameter int DATA_W = 16
) (
    input  logic [BANK_W-1:0] bank_i,
    input  logic [COL_W-1:0]  col_i,
    output logic [DATA_W-1:0] word_o
);
    localparam int PAD_W = DATA_W - BANK_W - COL_W;

    // Fixed content pattern: bank in the top bits, column in the low bits.
    assign word_o = {bank_i, {PAD_W{1'b0}}, col_i};
endmodule

// File: rtl/sdram_rd_ctrl.sv
module sdram_rd_ctrl
    import sdram_rd_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        bl_sel,
    input  logic              rd_en,
    input  logic [BANK_W-1:0] rd_bank,
    input  logic [COL_W-1:0]  rd_col,
    input  logic              pre_en,
    input  logic [BANK_W-1:0] pre_bank,
    output logic              iss_v,
    output logic [BANK_W-1:0] iss_bank,
    output logic [COL_W-1:0]  iss_col,
    output logic              err_o
);
    typedef struct packed {
        logic              active;
        logic [BANK_W-1:0] bank;
        logic [COL_W-1:0]  start;
        logic [IDX_W-1:0]  idx;
        logic              err;
    } state_t;

    state_t s_d, s_q;
    logic [IDX_W:0] bl_words;
    logic last, conflict, cut;

    sdram_rd_addr #(.COL_W(COL_W)) u_addr (
        .start_i(s_q.start),
        .idx_i  (s_q.idx),
        .bl_sel (bl_sel),
        .col_o  (iss_col)
    );

    assign bl_words = {{IDX_W{1'b0}}, 1'b1} << bl_sel;
    assign last     = ({1'b0, s_q.idx} == (bl_words - 1'b1));
    assign conflict = rd_en && pre_en && (pre_bank == rd_bank);
    assign cut      = pre_en && (pre_bank == s_q.bank);

    always_comb begin
        s_d     = s_q;
        s_d.err = conflict;
        if (s_q.active) begin
            s_d.idx = s_q.idx + 1'b1;
            if (last) s_d.active = 1'b0;
        end
        // The word issued this cycle still leaves; only later ones stop.
        if (cut) s_d.active = 1'b0;
        if (rd_en && !conflict) begin
            s_d.active = 1'b1;
            s_d.bank   = rd_bank;
            s_d.start  = rd_col;
            s_d.idx    = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign iss_v    = s_q.active;
    assign iss_bank = s_q.bank;
    assign err_o    = s_q.err;

    // R6: precharge to the reading bank stops further issue
    a_r6_pre_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_en && !rd_en && iss_v && pre_bank == iss_bank) |=> !iss_v);

    // R8: precharge to another bank leaves the burst running
    a_r8_other_bank: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_en && !rd_en && iss_v && pre_bank != iss_bank && !last) |=> iss_v);

    // R10: same-cycle conflict raises the flag
    a_r10_err_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && pre_en && pre_bank == rd_bank) |=> err_o);

    // R10: a conflicting read starts nothing
    a_r10_no_start: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && pre_en && pre_bank == rd_bank && !iss_v) |=> !iss_v);
endmodule

// File: rtl/sdram_rd_pipe.sv
module sdram_rd_pipe
    import sdram_rd_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cl_sel,
    input  logic              in_v,
    input  logic [DATA_W-1:0] in_data,
    output logic              oe_o,
    output logic [DATA_W-1:0] dq_o
);
    localparam int TAP_LO = MIN_CL - 1;
    localparam int TAP_HI = MAX_CL - 1;

    typedef struct packed {
        logic              v;
        logic [DATA_W-1:0] d;
    } stage_t;

    stage_t [MAX_CL-1:0] p_d, p_q;
    stage_t tap;

    always_comb begin
        p_d[0] = {in_v, (in_v ? in_data : {DATA_W{1'b0}})};
        for (int i = 1; i < MAX_CL; i++) p_d[i] = p_q[i-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign tap  = cl_sel ? p_q[TAP_HI] : p_q[TAP_LO];
    assign oe_o = tap.v;
    assign dq_o = tap.d;

    // R9: a quiet bus carries zero
    a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_o |-> dq_o == '0);
endmodule

// File: rtl/sdram_rd_seq.sv
module sdram_rd_seq
    import sdram_rd_pkg::*;
#(
    parameter int COL_W  = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cl_sel,
    input  logic [1:0]        bl_sel,
    input  logic              rd_en,
    input  logic [1:0]        rd_bank,
    input  logic [COL_W-1:0]  rd_col,
    input  logic              pre_en,
    input  logic [1:0]        pre_bank,
    output logic [DATA_W-1:0] dq_o,
    output logic              oe_o,
    output logic              err_o
);
    logic              iss_v;
    logic [BANK_W-1:0] iss_bank;
    logic [COL_W-1:0]  iss_col;
    logic [DATA_W-1:0] iss_word;

    sdram_rd_ctrl #(.COL_W(COL_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .bl_sel(bl_sel),
        .rd_en(rd_en), .rd_bank(rd_bank), .rd_col(rd_col),
        .pre_en(pre_en), .pre_bank(pre_bank),
        .iss_v(iss_v), .iss_bank(iss_bank), .iss_col(iss_col),
        .err_o(err_o)
    );

    sdram_rd_store #(.COL_W(COL_W), .DATA_W(DATA_W)) u_store (
        .bank_i(iss_bank), .col_i(iss_col), .word_o(iss_word)
    );

    sdram_rd_pipe #(.DATA_W(DATA_W)) u_pipe (
        .clk(clk), .rst_n(rst_n), .cl_sel(cl_sel),
        .in_v(iss_v), .in_data(iss_word),
        .oe_o(oe_o), .dq_o(dq_o)
    );

    // R2: with latency 3, the bus follows the issue stream three clocks later
    a_r2_cl3_delay: assert property (@(posedge clk) disable iff (!rst_n)
        cl_sel |-> oe_o == $past(iss_v, 3));

    // R2: with latency 2, two clocks later
    a_r2_cl2_delay: assert property (@(posedge clk) disable iff (!rst_n)
        !cl_sel |-> oe_o == $past(iss_v, 2));
endmodule

// File: tb/sim_sdram_rd_seq.sv
module sim_sdram_rd_seq;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cl_sel = 1'b0;
    logic [1:0]  bl_sel = 2'd2;
    logic        rd_en = 1'b0;
    logic [1:0]  rd_bank = '0;
    logic [7:0]  rd_col = '0;
    logic        pre_en = 1'b0;
    logic [1:0]  pre_bank = '0;
    logic [15:0] dq_o;
    logic        oe_o;
    logic        err_o;

    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;
    bit mon_en = 1'b0;
    bit done = 1'b0;

    typedef struct {
        int          at;
        logic [15:0] data;
        string       tag;
    } exp_t;
    exp_t q[$];

    sdram_rd_seq u0 (
        .clk(clk), .rst_n(rst_n), .cl_sel(cl_sel), .bl_sel(bl_sel),
        .rd_en(rd_en), .rd_bank(rd_bank), .rd_col(rd_col),
        .pre_en(pre_en), .pre_bank(pre_bank),
        .dq_o(dq_o), .oe_o(oe_o), .err_o(err_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [15:0] exp_word(int b, int c, int i, int bl);
        logic [7:0] col;
        col = 8'((c & ~(bl - 1)) | ((c + i) & (bl - 1)));
        return {2'(b), 6'b0, col};                     // R4 column, R5 content
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // Monitor: pops scheduled words; any other cycle must be quiet (R9).
    always @(negedge clk) begin
        if (mon_en) begin
            if (q.size() > 0 && q[0].at == cyc) begin
                check(oe_o == 1'b1, {q[0].tag, " oe"}, int'(oe_o), 1);
                check(dq_o == q[0].data, {q[0].tag, " dq"}, int'(dq_o), int'(q[0].data));
                void'(q.pop_front());
            end else begin
                check(oe_o == 1'b0 && dq_o == 16'h0, "R9 idle bus", int'({oe_o, dq_o}), 0);
            end
        end
    end

    // gap < 0: no precharge; otherwise precharge to pb sampled gap edges after the read
    task automatic run_burst(input int b, input int c, input int gap, input int pb,
                             input string tag);
        int n0, bl, cl, nw;
        @(negedge clk);
        n0 = cyc;
        bl = 1 << bl_sel;
        cl = cl_sel ? 3 : 2;
        rd_en = 1'b1; rd_bank = 2'(b); rd_col = 8'(c);
        if (gap == 0) begin pre_en = 1'b1; pre_bank = 2'(pb); end
        nw = bl;
        if (gap >= 0 && pb == b && gap < bl) nw = gap;
        for (int i = 0; i < nw; i++) begin
            exp_t e;
            e.at = n0 + 1 + cl + i;
            e.data = exp_word(b, c, i, bl);
            e.tag = tag;
            q.push_back(e);
        end
        @(negedge clk);
        rd_en = 1'b0; pre_en = 1'b0;
        if (gap == 0 && pb == b) check(err_o == 1'b1, "R10 err raised", int'(err_o), 1);
        else                     check(err_o == 1'b0, "R10 err quiet", int'(err_o), 0);
        for (int j = 1; j < 20; j++) begin
            pre_en = (j == gap);
            pre_bank = 2'(pb);
            @(negedge clk);
        end
        pre_en = 1'b0;
        check(q.size() == 0, {tag, " all words seen"}, q.size(), 0);
        q.delete();
    endtask

    initial begin
        repeat (5) @(negedge clk);
        check(oe_o == 1'b0 && dq_o == 16'h0 && err_o == 1'b0, "R1 in reset",
              int'({err_o, oe_o, dq_o}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(oe_o == 1'b0 && dq_o == 16'h0 && err_o == 1'b0, "R1 after reset",
              int'({err_o, oe_o, dq_o}), 0);
        mon_en = 1'b1;

        // CL 2, BL 4
        cl_sel = 1'b0; bl_sel = 2'd2;
        run_burst(1, 5, -1, 1, "R2 R4 R5 full wrap");
        run_burst(2, 8, 1, 2, "R6 gap1 cl2");
        run_burst(2, 8, 2, 2, "R6 gap2 cl2");
        run_burst(2, 8, 3, 2, "R6 gap3 cl2");
        run_burst(0, 3, 4, 0, "R7 gap4");
        run_burst(3, 0, 6, 3, "R7 gap6");

        // CL 3, BL 4
        cl_sel = 1'b1;
        run_burst(1, 9, -1, 1, "R2 cl3 full");
        run_burst(1, 9, 1, 1, "R6 gap1 cl3");
        run_burst(1, 9, 2, 1, "R6 gap2 cl3");
        run_burst(1, 9, 3, 1, "R6 gap3 cl3");
        run_burst(2, 6, 1, 0, "R8 other bank");
        run_burst(1, 2, 0, 3, "R8 same cycle other bank");
        run_burst(0, 1, 0, 0, "R10 conflict");

        // Other burst lengths
        bl_sel = 2'd3;
        run_burst(2, 8'h3D, -1, 2, "R3 R4 bl8");
        run_burst(3, 8'h10, 5, 3, "R6 bl8 gap5");
        bl_sel = 2'd0;
        run_burst(1, 7, -1, 1, "R3 bl1");
        bl_sel = 2'd1;
        cl_sel = 1'b0;
        run_burst(3, 9, -1, 3, "R3 R4 bl2");
        run_burst(3, 9, 1, 3, "R6 bl2 gap1");

        mon_en = 1'b0;
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule